// File: doc/BRIEF.md
# Shared-Precompute Radix-4 Coefficient Multiplier

This block forms the full unsigned product of a data word and a programmable coefficient without building a partial-product array. A small precomputer derives six multiples of the data word once per operand: 1x, 2x and 3x, and 4x, 8x and 12x. Only two adders are needed, one for 3x and one for 12x. The other four multiples are wiring shifts. The same six multiples serve every coefficient width.

The coefficient is cut into 2-bit groups, starting at the least significant end. Each group is the select code of its own 4:1 multiplexer. The multiplexers alternate between the low set {0, 1x, 2x, 3x} and the high set {0, 4x, 8x, 12x}. One low and one high multiplexer form a select unit, and their sum equals the data word times one 4-bit coefficient nibble. The select-unit sums are shifted by four bits per nibble position and added into a product that is not truncated.

The product always leaves through a register. An optional register stage on the operand inputs sets the latency to one or two clock cycles. The datapath widths (8x8, 16x16 and any coefficient width that is a multiple of four) come from parameters.

Top module: `r4_share_mult`

## Requirements
- R1: `prod_out` equals the exact unsigned product `x_in * coef_in`, DATA_W+COEF_W bits wide, with no truncation or rounding, for every operand pair.
- R2: The precomputed multiples obey 2x = 1x<<1, 4x = 2x<<1, 8x = 2x<<2 and 12x = 3x<<2, with 3x formed by one addition and 12x by one addition.
- R3: Coefficient bits [2g+1:2g] form group g. An even-numbered group (g = 0, 2, ...) with code 0..3 contributes 0, 1x, 2x or 3x. An odd-numbered group contributes 0, 4x, 8x or 12x. The sum inside select unit k equals x times coefficient bits [4k+3:4k].
- R4: Select unit k enters the product shifted left by 4k bits, so a coefficient with a single nonzero nibble k gives x * nibble * 16^k.
- R5: A coefficient of zero gives a product of zero for any data word, including all ones.
- R6: A data word of zero gives a product of zero for any coefficient, including all ones.
- R7: The result for operands present at a rising clock edge appears on `prod_out` after exactly 1+IN_REG rising edges, and the output shows no trace of them before then.
- R8: While `rst_n` is low, `prod_out` reads zero whatever the inputs are. After release the pipeline holds only zero products until new operands arrive.
- R9: All-ones operands give (2^DATA_W-1)*(2^COEF_W-1) without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the operand and product registers |
| x_in | input | DATA_W | Unsigned data word |
| coef_in | input | COEF_W | Unsigned coefficient; COEF_W must be a multiple of 4 |
| prod_out | output | DATA_W+COEF_W | Registered full-width unsigned product |

## Verification
A product is due 1+IN_REG rising edges after its operands are sampled. The bench exercises a 16x16 instance with the input stage, so its latency is two cycles, and an 8x8 instance without it, so its latency is one cycle. For each instance, the bench keeps a queue of expected products exactly as deep as that latency. At every falling edge it pops the oldest entry and compares it with the output, then pushes the product of the operands it drives. A result that arrives a cycle early or late therefore miscompares on both neighbouring vectors. The R7 pulse sequence places one nonzero operand pair between zero pairs so that any such offset shows up directly.

// File: rtl/rmul_pkg.sv
`timescale 1ns/1ps
package rmul_pkg;

  // 2-bit coefficient group code, read as "how many of the set's base multiples"
  typedef enum logic [1:0] {
    GS_NONE    = 2'd0,
    GS_ONCE    = 2'd1,
    GS_TWICE   = 2'd2,
    GS_THRICE  = 2'd3
  } grp_sel_e;

  // Weight a group code carries inside its nibble: low groups count 1, high groups 4
  function automatic logic [3:0] grp_weight(input logic [1:0] code, input logic high);
    return high ? {code, 2'b00} : {2'b00, code};
  endfunction

  // Nibble value rebuilt from the two group codes that feed one select unit
  function automatic logic [3:0] nibble_of(input logic [1:0] lo, input logic [1:0] hi);
    return grp_weight(lo, 1'b0) + grp_weight(hi, 1'b1);
  endfunction

endpackage

// File: rtl/rmul_precompute.sv
`timescale 1ns/1ps
module rmul_precompute #(
  parameter int DATA_W = 16,
  localparam int MW = DATA_W + 4
) (
  input  logic [DATA_W-1:0] x,
  output logic [MW-1:0]     m1,
  output logic [MW-1:0]     m2,
  output logic [MW-1:0]     m3,
  output logic [MW-1:0]     m4,
  output logic [MW-1:0]     m8,
  output logic [MW-1:0]     m12
);
  // four multiples are pure wiring shifts, two need an adder each
  assign m1  = MW'(x);
  assign m2  = m1 << 1;
  assign m4  = m1 << 2;
  assign m8  = m1 << 3;
  assign m3  = m1 + m2;
  assign m12 = m4 + m8;
endmodule

// File: rtl/rmul_group_mux.sv
`timescale 1ns/1ps
module rmul_group_mux #(
  parameter int W = 20
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] opt_a,
  input  logic [W-1:0] opt_b,
  input  logic [W-1:0] opt_c,
  output logic [W-1:0] pick
);
  import rmul_pkg::*;

  grp_sel_e code;
  assign code = grp_sel_e'(sel);

  always_comb begin
    case (code)
      GS_ONCE:   pick = opt_a;
      GS_TWICE:  pick = opt_b;
      GS_THRICE: pick = opt_c;
      default:   pick = '0;
    endcase
  end
endmodule

// File: rtl/rmul_select_unit.sv
`timescale 1ns/1ps
module rmul_select_unit #(
  parameter int MW = 20
) (
  input  logic [1:0]    grp_lo,
  input  logic [1:0]    grp_hi,
  input  logic [MW-1:0] m1,
  input  logic [MW-1:0] m2,
  input  logic [MW-1:0] m3,
  input  logic [MW-1:0] m4,
  input  logic [MW-1:0] m8,
  input  logic [MW-1:0] m12,
  output logic [MW-1:0] nib_sum
);
  logic [MW-1:0] pick_lo;
  logic [MW-1:0] pick_hi;

  rmul_group_mux #(.W(MW)) lo_mux_i (
    .sel(grp_lo), .opt_a(m1), .opt_b(m2), .opt_c(m3), .pick(pick_lo)
  );

  rmul_group_mux #(.W(MW)) hi_mux_i (
    .sel(grp_hi), .opt_a(m4), .opt_b(m8), .opt_c(m12), .pick(pick_hi)
  );

  // at most 3x + 12x = 15x, which fits in DATA_W+4 bits
  assign nib_sum = pick_lo + pick_hi;
endmodule

// File: rtl/r4_share_mult.sv
`timescale 1ns/1ps
module r4_share_mult #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int IN_REG = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DATA_W-1:0]          x_in,
  input  logic [COEF_W-1:0]          coef_in,
  output logic [DATA_W+COEF_W-1:0]   prod_out
);
  localparam int PROD_W    = DATA_W + COEF_W;
  localparam int MW        = DATA_W + 4;
  localparam int NUM_UNITS = COEF_W / 4;

  if ((COEF_W % 4) != 0 || COEF_W < 4 || DATA_W < 1) begin : g_bad_cfg
    $error("r4_share_mult: COEF_W must be a nonzero multiple of 4 and DATA_W at least 1");
  end

  // operands as seen by the datapath (after the optional input stage)
  logic [DATA_W-1:0] op_x;
  logic [COEF_W-1:0] op_c;

  if (IN_REG != 0) begin : g_in_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        op_x <= '0;
        op_c <= '0;
      end else begin
        op_x <= x_in;
        op_c <= coef_in;
      end
    end
  end else begin : g_in_pass
    assign op_x = x_in;
    assign op_c = coef_in;
  end

  // shared multiples
  logic [MW-1:0] m1, m2, m3, m4, m8, m12;

  rmul_precompute #(.DATA_W(DATA_W)) pre_i (
    .x(op_x), .m1(m1), .m2(m2), .m3(m3), .m4(m4), .m8(m8), .m12(m12)
  );

  // one select unit per coefficient nibble, then a shift-add chain
  logic [NUM_UNITS-1:0][MW-1:0] unit_sum;
  logic [PROD_W-1:0]            acc [NUM_UNITS+1];
  logic [PROD_W-1:0]            prod_next;

  assign acc[0] = '0;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    rmul_select_unit #(.MW(MW)) su_i (
      .grp_lo (op_c[4*u+1 -: 2]),
      .grp_hi (op_c[4*u+3 -: 2]),
      .m1     (m1),
      .m2     (m2),
      .m3     (m3),
      .m4     (m4),
      .m8     (m8),
      .m12    (m12),
      .nib_sum(unit_sum[u])
    );
    assign acc[u+1] = acc[u] + (PROD_W'(unit_sum[u]) << (4 * u));
  end

  assign prod_next = acc[NUM_UNITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_out <= '0;
    else        prod_out <= prod_next;
  end
endmodule

// File: rtl/r4_share_mult_chk.sv
`timescale 1ns/1ps
module r4_share_mult_chk #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int IN_REG = 1,
  localparam int PROD_W    = DATA_W + COEF_W,
  localparam int MW        = DATA_W + 4,
  localparam int NUM_UNITS = COEF_W / 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [DATA_W-1:0]             x_in,
  input logic [COEF_W-1:0]             coef_in,
  input logic [PROD_W-1:0]             prod_out,
  input logic [DATA_W-1:0]             op_x,
  input logic [COEF_W-1:0]             op_c,
  input logic [MW-1:0]                 m1,
  input logic [MW-1:0]                 m2,
  input logic [MW-1:0]                 m3,
  input logic [MW-1:0]                 m4,
  input logic [MW-1:0]                 m8,
  input logic [MW-1:0]                 m12,
  input logic [NUM_UNITS-1:0][MW-1:0]  unit_sum
);
  import rmul_pkg::*;

  // edges seen since reset release, saturating
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_PRE_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    (m2 == (m1 << 1)) && (m4 == (m2 << 1)) && (m8 == (m2 << 2))); // R2

  AST_PRE_TWELVE: assert property (@(posedge clk) disable iff (!rst_n)
    m12 == (m3 << 2)); // R2

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit_chk
    AST_UNIT_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      unit_sum[k] == MW'(MW'(op_x) * MW'(nibble_of(op_c[4*k+1 -: 2], op_c[4*k+3 -: 2])))); // R3
  end

  AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) |-> prod_out == $past(PROD_W'(op_x) * PROD_W'(op_c))); // R1

  AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst != 2'd0) && ($past(op_c) == '0)) |-> prod_out == '0); // R5

  AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst != 2'd0) && ($past(op_x) == '0)) |-> prod_out == '0); // R6

  if (IN_REG != 0) begin : g_lat2
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> prod_out == PROD_W'($past(PROD_W'(x_in) * PROD_W'(coef_in), 2))); // R7
  end else begin : g_lat1
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1) |-> prod_out == $past(PROD_W'(x_in) * PROD_W'(coef_in))); // R7
  end
endmodule

bind r4_share_mult r4_share_mult_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .IN_REG(IN_REG)
) chk_i (.*);

// File: tb/r4_share_mult_tb_top.sv
`timescale 1ns/1ps
module r4_share_mult_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rst_n = 1'b0;
  logic [15:0] x16 = '0, c16 = '0;
  logic [31:0] p16;
  logic [7:0]  x8 = '0, c8 = '0;
  logic [15:0] p8;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit done    = 1'b0;

  // expected-result pipelines, as deep as each instance's latency
  logic [31:0] e16_q[$];
  string       l16_q[$];
  logic [15:0] e8_q[$];
  string       l8_q[$];

  r4_share_mult #(.DATA_W(16), .COEF_W(16), .IN_REG(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .x_in(x16), .coef_in(c16), .prod_out(p16)
  );

  r4_share_mult #(.DATA_W(8), .COEF_W(8), .IN_REG(0)) dut8_i (
    .clk(clk), .rst_n(rst_n), .x_in(x8), .coef_in(c8), .prod_out(p8)
  );

  task automatic check(input string req, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s %s: actual %h expected %h", req, tag, act, exp);
    end
  endtask

  // one cycle: check what is due now, then drive the next operands
  task automatic step(input logic [15:0] a16, input logic [15:0] b16,
                      input logic [7:0] a8, input logic [7:0] b8, input string req);
    @(negedge clk);
    check(l16_q.pop_front(), "16x16", p16, e16_q.pop_front());
    check(l8_q.pop_front(), "8x8", 32'(p8), 32'(e8_q.pop_front()));
    x16 = a16; c16 = b16; x8 = a8; c8 = b8;
    e16_q.push_back(32'(a16) * 32'(b16)); l16_q.push_back(req);
    e8_q.push_back(16'(a8) * 16'(b8));    l8_q.push_back(req);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
  endtask

  initial begin
    // R8: reset holds the product at zero even with live inputs
    x16 = 16'hBEEF; c16 = 16'h1234; x8 = 8'hA5; c8 = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "16x16 in reset", p16, 32'h0);
    check("R8", "8x8 in reset", 32'(p8), 32'h0);
    x16 = '0; c16 = '0; x8 = '0; c8 = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) begin e16_q.push_back(32'h0); l16_q.push_back("R8"); end
    e8_q.push_back(16'h0); l8_q.push_back("R8");

    // R5 / R6 / R9: zero and extreme operands
    step(16'hFFFF, 16'h0000, 8'hFF, 8'h00, "R5");
    step(16'h0000, 16'hFFFF, 8'h00, 8'hFF, "R6");
    step(16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF, "R9");
    step(16'h0000, 16'h0000, 8'h00, 8'h00, "R5");

    // R2: coefficients that lean on the two adder-built multiples
    step(16'hA5C3, 16'h0003, 8'hC3, 8'h03, "R2");
    step(16'hA5C3, 16'h000C, 8'hC3, 8'h0C, "R2");
    step(16'hFFFF, 16'h000F, 8'hFF, 8'h0F, "R2");

    // R3: one nonzero group at a time, every code
    for (int g = 0; g < 8; g++) begin
      for (int v = 1; v < 4; v++) begin
        step(16'hF00D, 16'(v << (2 * g)), 8'hB7, 8'(v << (2 * (g % 4))), "R3");
      end
    end
    step(16'h0123, 16'h0063, 8'h23, 8'h63, "R3");

    // R4: one full nibble at each position
    for (int u = 0; u < 4; u++) begin
      step(16'hFFFF, 16'(16'hF << (4 * u)), 8'hFF, 8'(8'hF << (4 * (u % 2))), "R4");
    end

    // R7: isolated nonzero pair between zero pairs
    step(16'h0000, 16'h0000, 8'h00, 8'h00, "R7");
    step(16'h1357, 16'h9BDF, 8'h57, 8'hDF, "R7");
    step(16'h0000, 16'h0000, 8'h00, 8'h00, "R7");
    step(16'h0000, 16'h0000, 8'h00, 8'h00, "R7");

    // R1: exhaustive 8x8, random 16x16 alongside
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        step(16'($urandom), 16'($urandom), 8'(a), 8'(b), "R1");
      end
    end

    // flush the results still in flight
    repeat (2) step(16'h0, 16'h0, 8'h0, 8'h0, "R1");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      err_cnt++;
      $display("FAIL R1 watchdog: actual run unfinished expected run finished");
      summary();
      $finish;
    end
  end
endmodule